// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block takes a single command that names a maintenance action on a range of virtual addresses, then carries it out one cache line at a time. A command consists of a 4-bit selector, a 3-bit opcode, a start and an end virtual address, and a privilege flag. The block decodes the pair, checks the privilege rule for that action, and then walks the range. For each line it first asks the translation port for a physical address. Once the translation is granted, it hands a line operation to the cache port.

Clean, invalidate and clean-and-invalidate actions are blocking. They hold the stall output while they run and report a translation fault precisely, through a fault pulse, a fault-address register and a fault-status register. Prefetch actions run in the background without stalling. Any fault they meet ends them silently. A new legal command accepted while a prefetch runs takes over the ports and abandons the prefetch, so only one walk uses the ports at any time.

Top module: `cache_range_seq`

## Requirements
- R1: The pair (selector, opcode) selects the action, and the action sets the code on `c_op_o`. (5,0) invalidates the instruction cache and gives code 0. (6,0) invalidates the data cache and gives code 1. (12,0) cleans the data cache and gives code 2. (12,1) prefetches instructions and gives code 3. (12,2) prefetches data and gives code 4. (14,0) cleans and invalidates the data cache and gives code 5.
- R2: Codes 0, 1 and 5 require the privilege flag. If one of them is accepted with the flag low, `undef_o` pulses high in the cycle after acceptance and no translation or cache request is issued.
- R3: Clean (code 2) and both prefetches (codes 3, 4) are accepted with the privilege flag low or high.
- R4: Any selector/opcode pair not listed in R1 makes `undef_o` pulse in the cycle after acceptance.
- R5: A command is accepted on a clock edge where `cmd_valid_i` is high and `stall_o` is low. For a legal blocking action with a non-empty range, `stall_o` is high from the cycle after acceptance until the edge that consumes the last cache acknowledge. Commands presented while `stall_o` is high are ignored.
- R6: A prefetch never raises `stall_o`. A legal command accepted while a prefetch walk is active abandons that walk and starts its own.
- R7: Lines are 32 bytes. The walk covers every line from the line of the start address up to and including the line of the end address, up to the top line of the address space. For each line, a translation request precedes a cache request that carries the returned physical address. The first request carries the start address unchanged, and later requests carry line-aligned addresses.
- R8: If the end address is numerically below the start address, `done_o` pulses in the cycle after acceptance and no line request is issued.
- R9: A translation fault during a blocking walk stops the walk, with no further requests and no `done_o`. `fault_o` pulses, `fault_addr_o` takes the faulting virtual address, and `fault_status_o` takes 5'b00101.
- R10: A translation fault during a prefetch stops that walk. `fault_o` and `done_o` stay low, and `fault_addr_o` and `fault_status_o` keep their values.
- R11: `done_o` pulses for one cycle, in the cycle after the edge that consumes the last cache acknowledge of a walk.
- R12: `tr_req_o` and `c_req_o`, together with their addresses, stay stable until acknowledged, unless a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command presented |
| cmd_sel_i | input | 4 | Register selector |
| cmd_opc_i | input | 3 | Opcode |
| cmd_start_i | input | AW | Start virtual address |
| cmd_end_i | input | AW | End virtual address |
| cmd_priv_i | input | 1 | Privileged command |
| tr_req_o | output | 1 | Translation request |
| tr_va_o | output | AW | Virtual address to translate |
| tr_ack_i | input | 1 | Translation answered |
| tr_fault_i | input | 1 | Translation failed |
| tr_pa_i | input | AW | Translated physical address |
| c_req_o | output | 1 | Cache line operation request |
| c_op_o | output | 3 | Line operation code (R1) |
| c_addr_o | output | AW | Physical address for the line |
| c_ack_i | input | 1 | Cache operation finished |
| stall_o | output | 1 | Pipeline stall for blocking actions |
| done_o | output | 1 | Walk completed |
| undef_o | output | 1 | Undefined-command trap |
| fault_o | output | 1 | Precise fault pulse |
| fault_addr_o | output | AW | Faulting virtual address |
| fault_status_o | output | 5 | Fault status code |

## Verification
The bench builds the block with AW=16 and LINE_BYTES=32. This gives a 2048-line address space, so a walk that ends on the very top line can be run in a few cycles, and a 128-line background prefetch lasts long enough to be interrupted part-way through. The translation responder adds one wait cycle before each answer, which exercises request holding, and it can be set to fault on one chosen line.

// File: rtl/crm_pkg.sv
`timescale 1ns/1ps
package crm_pkg;

  typedef enum logic [2:0] {
    LOP_INV_I   = 3'd0,
    LOP_INV_D   = 3'd1,
    LOP_CLEAN_D = 3'd2,
    LOP_PF_I    = 3'd3,
    LOP_PF_D    = 3'd4,
    LOP_CLINV_D = 3'd5
  } line_op_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_XLATE,
    WS_CACHE
  } walk_st_e;

  localparam int unsigned FSTAT_W = 5;
  localparam logic [FSTAT_W-1:0] FSTAT_XLATE = 5'b00101;

  typedef struct packed {
    logic     legal;
    logic     undef;
    logic     blocking;
    line_op_e op;
  } dec_res_t;

endpackage

// File: rtl/crm_decode.sv
`timescale 1ns/1ps
module crm_decode
  import crm_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic [2:0] opc_i,
  input  logic       priv_i,
  output dec_res_t   res_o
);

  logic     known;
  logic     priv_only;
  logic     blk;
  line_op_e op;

  always_comb begin
    known     = 1'b1;
    priv_only = 1'b0;
    blk       = 1'b1;
    op        = LOP_CLEAN_D;
    case ({sel_i, opc_i})
      {4'd5,  3'd0}: begin op = LOP_INV_I;   priv_only = 1'b1; end
      {4'd6,  3'd0}: begin op = LOP_INV_D;   priv_only = 1'b1; end
      {4'd12, 3'd0}: begin op = LOP_CLEAN_D; end
      {4'd12, 3'd1}: begin op = LOP_PF_I;    blk = 1'b0; end
      {4'd12, 3'd2}: begin op = LOP_PF_D;    blk = 1'b0; end
      {4'd14, 3'd0}: begin op = LOP_CLINV_D; priv_only = 1'b1; end
      default:       known = 1'b0;
    endcase
  end

  always_comb begin
    res_o.undef    = !known || (priv_only && !priv_i);
    res_o.legal    = known && !(priv_only && !priv_i);
    res_o.blocking = blk;
    res_o.op       = op;
  end

endmodule

// File: rtl/crm_walker.sv
`timescale 1ns/1ps
module crm_walker
  import crm_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned OFFW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_va_i,
  input  logic [AW-1:0] end_va_i,
  input  line_op_e      op_i,
  input  logic          blk_i,
  output logic          tr_req_o,
  output logic [AW-1:0] tr_va_o,
  input  logic          tr_ack_i,
  input  logic          tr_fault_i,
  input  logic [AW-1:0] tr_pa_i,
  output logic          c_req_o,
  output line_op_e      c_op_o,
  output logic [AW-1:0] c_addr_o,
  input  logic          c_ack_i,
  output logic          busy_o,
  output logic          blk_o,
  output logic          done_o,
  output logic          flt_evt_o,
  output logic [AW-1:0] flt_va_o
);

  localparam int unsigned LW = AW - OFFW;

  walk_st_e      state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          cur_en;
  logic [LW-1:0] end_q;
  line_op_e      op_q;
  logic          blk_q;
  logic [AW-1:0] pa_q;
  logic          pa_en;
  logic          done_q, done_d;
  logic          last_line;
  logic          flt_evt;

  assign last_line = (cur_q[AW-1:OFFW] == end_q);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cur_en  = 1'b0;
    pa_en   = 1'b0;
    done_d  = 1'b0;
    flt_evt = 1'b0;
    if (start_i) begin
      cur_en = 1'b1;
      cur_d  = start_va_i;
      if (end_va_i < start_va_i) begin
        state_d = WS_IDLE;
        done_d  = 1'b1;
      end else begin
        state_d = WS_XLATE;
      end
    end else begin
      case (state_q)
        WS_XLATE: begin
          if (tr_ack_i) begin
            if (tr_fault_i) begin
              state_d = WS_IDLE;
              flt_evt = blk_q;
            end else begin
              pa_en   = 1'b1;
              state_d = WS_CACHE;
            end
          end
        end
        WS_CACHE: begin
          if (c_ack_i) begin
            if (last_line) begin
              state_d = WS_IDLE;
              done_d  = 1'b1;
            end else begin
              cur_en  = 1'b1;
              cur_d   = {cur_q[AW-1:OFFW] + LW'(1), {OFFW{1'b0}}};
              state_d = WS_XLATE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      op_q    <= LOP_INV_I;
      blk_q   <= 1'b0;
      pa_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (start_i) begin
        end_q <= end_va_i[AW-1:OFFW];
        op_q  <= op_i;
        blk_q <= blk_i;
      end
      if (cur_en) cur_q <= cur_d;
      if (pa_en)  pa_q  <= tr_pa_i;
    end
  end

  assign tr_req_o  = (state_q == WS_XLATE);
  assign tr_va_o   = cur_q;
  assign c_req_o   = (state_q == WS_CACHE);
  assign c_op_o    = op_q;
  assign c_addr_o  = pa_q;
  assign busy_o    = (state_q != WS_IDLE);
  assign blk_o     = blk_q;
  assign done_o    = done_q;
  assign flt_evt_o = flt_evt;
  assign flt_va_o  = cur_q;

  // R12: a pending translation request holds its address
  assert_tr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o && !tr_ack_i && !start_i) |=> (tr_req_o && $stable(tr_va_o)));

  // R12: a pending cache request holds its address and code
  assert_c_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_req_o && !c_ack_i && !start_i) |=> (c_req_o && $stable(c_addr_o) && $stable(c_op_o)));

  // R7: the walk never passes the end line
  assert_within_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o || c_req_o) |-> (cur_q[AW-1:OFFW] <= end_q));

endmodule

// File: rtl/crm_fault_log.sv
`timescale 1ns/1ps
module crm_fault_log
  import crm_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic [AW-1:0]      va_i,
  output logic               fault_o,
  output logic [AW-1:0]      addr_o,
  output logic [FSTAT_W-1:0] status_o
);

  logic               pulse_q;
  logic [AW-1:0]      addr_q;
  logic [FSTAT_W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= 1'b0;
      addr_q   <= '0;
      status_q <= '0;
    end else begin
      pulse_q <= evt_i;
      if (evt_i) begin
        addr_q   <= va_i;
        status_q <= FSTAT_XLATE;
      end
    end
  end

  assign fault_o  = pulse_q;
  assign addr_o   = addr_q;
  assign status_o = status_q;

  // R9: a fault pulse always carries the translation status
  assert_fault_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (status_o == FSTAT_XLATE));

endmodule

// File: rtl/cache_range_seq.sv
`timescale 1ns/1ps
module cache_range_seq
  import crm_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [3:0]         cmd_sel_i,
  input  logic [2:0]         cmd_opc_i,
  input  logic [AW-1:0]      cmd_start_i,
  input  logic [AW-1:0]      cmd_end_i,
  input  logic               cmd_priv_i,
  output logic               tr_req_o,
  output logic [AW-1:0]      tr_va_o,
  input  logic               tr_ack_i,
  input  logic               tr_fault_i,
  input  logic [AW-1:0]      tr_pa_i,
  output logic               c_req_o,
  output logic [2:0]         c_op_o,
  output logic [AW-1:0]      c_addr_o,
  input  logic               c_ack_i,
  output logic               stall_o,
  output logic               done_o,
  output logic               undef_o,
  output logic               fault_o,
  output logic [AW-1:0]      fault_addr_o,
  output logic [FSTAT_W-1:0] fault_status_o
);

  localparam int unsigned OFFW = $clog2(LINE_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  dec_res_t dec;
  logic     accept, start;
  logic     busy, blk;
  logic     undef_q;
  logic     flt_evt;
  logic [AW-1:0] flt_va;
  line_op_e walk_op;

  crm_decode u_dec (
    .sel_i  (cmd_sel_i),
    .opc_i  (cmd_opc_i),
    .priv_i (cmd_priv_i),
    .res_o  (dec)
  );

  assign stall_o = busy && blk;
  assign accept  = cmd_valid_i && !stall_o;
  assign start   = accept && dec.legal;

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) undef_q <= 1'b0;
    else         undef_q <= accept && dec.undef;
  end
  assign undef_o = undef_q;

  crm_walker #(.AW(AW), .OFFW(OFFW)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (srst_n),
    .start_i    (start),
    .start_va_i (cmd_start_i),
    .end_va_i   (cmd_end_i),
    .op_i       (dec.op),
    .blk_i      (dec.blocking),
    .tr_req_o   (tr_req_o),
    .tr_va_o    (tr_va_o),
    .tr_ack_i   (tr_ack_i),
    .tr_fault_i (tr_fault_i),
    .tr_pa_i    (tr_pa_i),
    .c_req_o    (c_req_o),
    .c_op_o     (walk_op),
    .c_addr_o   (c_addr_o),
    .c_ack_i    (c_ack_i),
    .busy_o     (busy),
    .blk_o      (blk),
    .done_o     (done_o),
    .flt_evt_o  (flt_evt),
    .flt_va_o   (flt_va)
  );
  assign c_op_o = walk_op;

  crm_fault_log #(.AW(AW)) u_flog (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .evt_i    (flt_evt),
    .va_i     (flt_va),
    .fault_o  (fault_o),
    .addr_o   (fault_addr_o),
    .status_o (fault_status_o)
  );

  // R2: a trapped command starts no walk
  assert_trap_no_walk_R2: assert property (@(posedge clk_i) disable iff (!srst_n)
    (accept && dec.undef && !busy) |=> (!tr_req_o && !c_req_o));

  // R5: a non-empty blocking command stalls from the next cycle
  assert_blocking_stall_R5: assert property (@(posedge clk_i) disable iff (!srst_n)
    (start && dec.blocking && !(cmd_end_i < cmd_start_i)) |=> stall_o);

  // R6: a prefetch never stalls
  assert_prefetch_no_stall_R6: assert property (@(posedge clk_i) disable iff (!srst_n)
    (start && !dec.blocking) |=> !stall_o);

  // R9 / R10: precise faults come only from stalled walks
  assert_fault_blocking_R9: assert property (@(posedge clk_i) disable iff (!srst_n)
    fault_o |-> $past(stall_o));

  // R11: completion and fault never coincide
  assert_done_excl_R11: assert property (@(posedge clk_i) disable iff (!srst_n)
    !(done_o && fault_o));

endmodule

// File: tb/cache_range_seq_tb_top.sv
`timescale 1ns/1ps
module cache_range_seq_tb_top;

  localparam int AW = 16;
  localparam int LB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [3:0]    cmd_sel;
  logic [2:0]    cmd_opc;
  logic [AW-1:0] cmd_start, cmd_end;
  logic          cmd_priv;
  logic          tr_req, tr_ack, tr_fault, c_req, c_ack;
  logic [AW-1:0] tr_va, tr_pa, c_addr, fault_addr;
  logic [2:0]    c_op;
  logic          stall, done, undef, fault;
  logic [4:0]    fault_status;

  int nvec = 0;
  int nerr = 0;
  int epoch = 0;
  int ncyc = 0;
  int last_log_cyc = 0;
  logic [AW-1:0] fault_va = 16'h0001;
  logic [2:0]    log_op [0:1023];
  logic [AW-1:0] log_addr [0:1023];
  int log_n = 0;
  bit tw = 1'b0;
  int tw_ep = 0;
  logic [AW-1:0] tw_va;

  cache_range_seq #(.AW(AW), .LINE_BYTES(LB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_sel_i(cmd_sel), .cmd_opc_i(cmd_opc),
    .cmd_start_i(cmd_start), .cmd_end_i(cmd_end), .cmd_priv_i(cmd_priv),
    .tr_req_o(tr_req), .tr_va_o(tr_va), .tr_ack_i(tr_ack), .tr_fault_i(tr_fault), .tr_pa_i(tr_pa),
    .c_req_o(c_req), .c_op_o(c_op), .c_addr_o(c_addr), .c_ack_i(c_ack),
    .stall_o(stall), .done_o(done), .undef_o(undef), .fault_o(fault),
    .fault_addr_o(fault_addr), .fault_status_o(fault_status)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    ncyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // translation responder (one wait cycle) and cache responder
  initial begin
    tr_ack = 1'b0; tr_fault = 1'b0; tr_pa = '0; c_ack = 1'b0;
    forever begin
      @(negedge clk);
      tr_ack = 1'b0; tr_fault = 1'b0; c_ack = 1'b0;
      if (tr_req) begin
        if (!tw || tw_ep != epoch) begin
          tw = 1'b1; tw_ep = epoch; tw_va = tr_va;
        end else begin
          chk(tr_va == tw_va, "R12", "translate VA held", 32'(tr_va), 32'(tw_va));
          tr_ack = 1'b1;
          tr_fault = (tr_va == fault_va);
          tr_pa = tr_va + 16'h4000;
          tw = 1'b0;
        end
      end else begin
        tw = 1'b0;
      end
      if (c_req) begin
        c_ack = 1'b1;
        if (log_n < 1024) begin
          log_op[log_n] = c_op;
          log_addr[log_n] = c_addr;
        end
        log_n++;
        last_log_cyc = ncyc;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
    $finish;
  end

  task automatic issue(input logic [3:0] s, input logic [2:0] o,
                       input logic [AW-1:0] a, input logic [AW-1:0] e, input logic p);
    @(negedge clk);
    cmd_sel = s; cmd_opc = o; cmd_start = a; cmd_end = e; cmd_priv = p;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 epoch++;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_wait(output bit gd, output bit gf, output bit gu, output int sc);
    gd = 0; gf = 0; gu = 0; sc = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done || fault || undef) begin
        gd = done; gf = fault; gu = undef;
        break;
      end
      if (stall) sc++;
      @(negedge clk);
    end
    if (gd) chk(ncyc == last_log_cyc + 1, "R11", "done one cycle after last ack",
                32'(ncyc), 32'(last_log_cyc + 1));
  endtask

  task automatic expect_ops(input int b, input int n, input logic [2:0] op,
                            input logic [AW-1:0] first, input string tag);
    chk(log_n == b + n, tag, "line op count", 32'(log_n - b), 32'(n));
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] va;
      va = (i == 0) ? first : ((first & 16'hFFE0) + 16'(32 * i));
      chk(log_op[b+i] == op, "R1", "line op code", 32'(log_op[b+i]), 32'(op));
      chk(log_addr[b+i] == va + 16'h4000, "R7", "line address",
          32'(log_addr[b+i]), 32'(va + 16'h4000));
    end
  endtask

  task automatic t_reset();
    chk({stall, done, undef, fault, tr_req, c_req} == 6'b0, "R5", "outputs idle after reset",
        32'({stall, done, undef, fault, tr_req, c_req}), 32'(0));
    chk(fault_addr == '0 && fault_status == '0, "R9", "fault registers cleared",
        32'({fault_addr, fault_status}), 32'(0));
  endtask

  task automatic t_clean_unpriv();
    int b; bit gd, gf, gu; int sc;
    b = log_n;
    issue(4'd12, 3'd0, 16'h0105, 16'h0164, 1'b0);
    run_wait(gd, gf, gu, sc);
    chk({gd, gf, gu} == 3'b100, "R3", "unprivileged clean completes", 32'({gd, gf, gu}), 32'(4));
    chk(sc > 0, "R5", "clean stalled", 32'(sc), 32'(1));
    chk(stall == 1'b0, "R5", "stall released at done", 32'(stall), 32'(0));
    expect_ops(b, 4, 3'd2, 16'h0105, "R7");
  endtask

  task automatic t_inv_block();
    int b; bit gd, gf, gu; int sc;
    b = log_n;
    issue(4'd6, 3'd0, 16'h0400, 16'h045F, 1'b1);
    chk(stall == 1'b1, "R5", "stall after blocking accept", 32'(stall), 32'(1));
    issue(4'd7, 3'd0, 16'h0000, 16'h0000, 1'b1);
    run_wait(gd, gf, gu, sc);
    chk({gd, gf, gu} == 3'b100, "R5", "command under stall ignored", 32'({gd, gf, gu}), 32'(4));
    chk(stall == 1'b0, "R5", "stall low at done", 32'(stall), 32'(0));
    expect_ops(b, 3, 3'd1, 16'h0400, "R7");
  endtask

  task automatic t_priv_trap(input logic [3:0] s);
    int b;
    b = log_n;
    issue(s, 3'd0, 16'h0800, 16'h08FF, 1'b0);
    chk(undef == 1'b1, "R2", "unprivileged trap", 32'(undef), 32'(1));
    chk(stall == 1'b0, "R2", "no stall on trap", 32'(stall), 32'(0));
    repeat (6) @(negedge clk);
    chk(log_n == b && !tr_req, "R2", "no line ops after trap", 32'(log_n - b), 32'(0));
  endtask

  task automatic t_unknown(input logic [3:0] s, input logic [2:0] o);
    issue(s, o, 16'h0800, 16'h08FF, 1'b1);
    chk(undef == 1'b1, "R4", "unknown pair trap", 32'(undef), 32'(1));
    @(negedge clk);
    chk(undef == 1'b0 && !tr_req, "R4", "trap is one pulse", 32'(undef), 32'(0));
  endtask

  task automatic t_empty();
    int b; bit gd, gf, gu; int sc;
    b = log_n;
    issue(4'd12, 3'd0, 16'h0200, 16'h01E0, 1'b0);
    chk(done == 1'b1 && undef == 1'b0, "R8", "empty range done", 32'(done), 32'(1));
    chk(stall == 1'b0, "R8", "empty range no stall", 32'(stall), 32'(0));
    issue(4'd14, 3'd0, 16'h0210, 16'h0205, 1'b1);
    chk(done == 1'b1, "R8", "end below start in one line", 32'(done), 32'(1));
    repeat (5) @(negedge clk);
    chk(log_n == b, "R8", "no line ops", 32'(log_n - b), 32'(0));
    issue(4'd12, 3'd0, 16'h0210, 16'h0210, 1'b0);
    run_wait(gd, gf, gu, sc);
    chk(gd, "R7", "single line done", 32'(gd), 32'(1));
    expect_ops(b, 1, 3'd2, 16'h0210, "R7");
  endtask

  task automatic t_block_fault();
    int b; bit gd, gf, gu; int sc; bit seen;
    fault_va = 16'h2040;
    b = log_n;
    issue(4'd14, 3'd0, 16'h2000, 16'h20FF, 1'b1);
    run_wait(gd, gf, gu, sc);
    chk({gd, gf} == 2'b01, "R9", "blocking fault raised", 32'({gd, gf}), 32'(1));
    chk(fault_addr == 16'h2040, "R9", "fault address", 32'(fault_addr), 32'h2040);
    chk(fault_status == 5'b00101, "R9", "fault status", 32'(fault_status), 32'h5);
    expect_ops(b, 2, 3'd5, 16'h2000, "R9");
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done || tr_req || c_req || stall) seen = 1;
    end
    chk(!seen, "R9", "walk stopped after fault", 32'(seen), 32'(0));
  endtask

  task automatic t_pf_fault();
    int b; bit seen;
    fault_va = 16'h2060;
    b = log_n;
    issue(4'd12, 3'd2, 16'h2000, 16'h20FF, 1'b0);
    chk(stall == 1'b0, "R6", "prefetch no stall", 32'(stall), 32'(0));
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fault || done || stall) seen = 1;
    end
    chk(!seen, "R10", "silent prefetch fault", 32'(seen), 32'(0));
    chk(fault_addr == 16'h2040 && fault_status == 5'b00101, "R10", "fault regs unchanged",
        32'(fault_addr), 32'h2040);
    chk(!tr_req && !c_req, "R10", "prefetch walk ended", 32'({tr_req, c_req}), 32'(0));
    expect_ops(b, 3, 3'd4, 16'h2000, "R10");
  endtask

  task automatic t_pf_abandon();
    int b, n, pf; bit gd, gf, gu; int sc; bit st, bad;
    fault_va = 16'h0001;
    b = log_n;
    issue(4'd12, 3'd1, 16'h3000, 16'h3FFF, 1'b0);
    st = 0;
    for (int i = 0; i < 10; i++) begin
      if (stall) st = 1;
      @(negedge clk);
    end
    chk(!st, "R6", "background prefetch no stall", 32'(st), 32'(0));
    issue(4'd12, 3'd0, 16'h5000, 16'h5030, 1'b0);
    chk(stall == 1'b1, "R6", "blocking accepted over prefetch", 32'(stall), 32'(1));
    run_wait(gd, gf, gu, sc);
    chk(gd, "R6", "takeover walk done", 32'(gd), 32'(1));
    n = log_n;
    chk(log_op[n-2] == 3'd2 && log_addr[n-2] == 16'h9000, "R6", "takeover line 0",
        32'(log_addr[n-2]), 32'h9000);
    chk(log_op[n-1] == 3'd2 && log_addr[n-1] == 16'h9020, "R6", "takeover line 1",
        32'(log_addr[n-1]), 32'h9020);
    pf = n - 2 - b;
    chk(pf > 0 && pf < 128, "R6", "prefetch abandoned", 32'(pf), 32'(3));
    bad = 0;
    for (int i = b; i < n - 2; i++) if (log_op[i] != 3'd3) bad = 1;
    chk(!bad, "R1", "prefetch instruction code", 32'(bad), 32'(0));
  endtask

  task automatic t_top();
    int b; bit gd, gf, gu; int sc;
    b = log_n;
    issue(4'd12, 3'd0, 16'hFFC0, 16'hFFFF, 1'b0);
    run_wait(gd, gf, gu, sc);
    chk(gd, "R7", "top of space done", 32'(gd), 32'(1));
    expect_ops(b, 2, 3'd2, 16'hFFC0, "R7");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_sel = '0; cmd_opc = '0;
    cmd_start = '0; cmd_end = '0; cmd_priv = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean_unpriv();
    t_inv_block();
    t_priv_trap(4'd5);
    t_priv_trap(4'd6);
    t_priv_trap(4'd14);
    t_unknown(4'd12, 3'd3);
    t_unknown(4'd7, 3'd0);
    t_unknown(4'd5, 3'd1);
    t_empty();
    t_block_fault();
    t_pf_fault();
    t_pf_abandon();
    t_top();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule